// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether a memory access may use a translated page. It combines three separate sources of permission. The first is the page entry's protection code together with a key chosen from the segment. The second is the page's no-execute and guarded flags. The third is a pair of per-key mask registers: one covers loads and stores, the other covers instruction fetches. The block outputs the set of rights that survives all three sources, a grant flag for the access being attempted, and fault-status bits that name every source that took away the needed right.

It sits in the translation path after the page entry has been found. All decision logic is combinational. A single clock-enabled output register stage, loaded when `chk_en` is high, lets the result line up with a pipelined lookup. The table walk and interrupt delivery are handled elsewhere.

Top module: `perm_chk_top`

## Requirements
- R1: While `rst_n` is low, and until the first enabled check after reset completes, `res_vld`, `res_perm`, `res_grant` and `res_fault` are all zero.
- R2: The basic-protection code is the 3-bit value {`pp_hi`, `pp_lo`}. With the selected key 0: codes 0, 1 and 2 give read+write+execute, codes 3 and 6 give read+execute, and every other code gives nothing. With the selected key 1: code 2 gives read+write+execute, codes 1 and 3 give read+execute, and every other code gives nothing.
- R3: The selected key is `seg_kp` when `prob_state` is 1 (problem state) and `seg_ks` when it is 0.
- R4: When `no_exec` or `guarded` is 1, only execute permission is removed. Read and write are unaffected.
- R5: For storage key k, the access-mask slice is `amr[2*(31-k)+1 : 2*(31-k)]`. A 1 in the upper bit removes write permission, and a 1 in the lower bit removes read permission. This applies in `mmu_mode` 1, 2 and 3.
- R6: A 1 in `iamr[2*(31-k)]` removes execute permission only, and only in `mmu_mode` 2 or 3. In mode 1, `iamr` has no effect.
- R7: In `mmu_mode` 0, neither `amr` nor `iamr` has any effect on the permission, the grant or the fault bits.
- R8: `res_perm` (bit0 read, bit1 write, bit2 execute) is the AND of the three source masks. `res_grant` is 1 exactly when the right required by `acc_type` is present: fetch (0) needs execute, load (1) needs read, store (2) needs write, and code 3 is treated as a load.
- R9: On a denied fetch, `res_fault` bit1 (no-execute/guard) is set if that source removed execute. Otherwise bit0 (basic protection) is set if the basic check removed execute. Independently of both, bit2 (key mask) is set if the mask source removed execute.
- R10: On a denied load or store, bit0 is set if the basic check lacks the needed right, bit3 is set for a store, and bit2 is set if the mask source lacks the needed right. Bit1 is never set for a load or store.
- R11: When the access is granted, `res_fault` is zero.
- R12: When `chk_en` is 1, the result for the current inputs appears on the outputs after the next rising edge and `res_vld` goes to 1. When `chk_en` is 0, `res_perm`, `res_grant` and `res_fault` hold their values and `res_vld` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | Load a new result into the output stage |
| acc_type | input | 2 | 0 fetch, 1 load, 2 store, 3 treated as load |
| prob_state | input | 1 | 1 when the access is made in problem (user) state |
| seg_kp | input | 1 | Segment key used in problem state |
| seg_ks | input | 1 | Segment key used in supervisor state |
| pp_lo | input | 2 | Low two bits of the page protection code |
| pp_hi | input | 1 | High bit of the page protection code |
| no_exec | input | 1 | Page is no-execute |
| guarded | input | 1 | Page is guarded |
| stor_key | input | KEY_W | Storage key of the page |
| mmu_mode | input | 2 | 0 no key masks, 1 data masks, 2/3 data and fetch masks |
| amr | input | 2*2**KEY_W | Load/store mask register, two bits per key |
| iamr | input | 2*2**KEY_W | Fetch mask register, two bits per key |
| res_vld | output | 1 | Result loaded in the previous cycle |
| res_perm | output | 3 | Surviving rights: bit0 read, bit1 write, bit2 execute |
| res_grant | output | 1 | Required right present |
| res_fault | output | 4 | bit0 basic, bit1 no-exec/guard, bit2 key mask, bit3 store |

## Verification
The main case to exercise is one denial in which more than one source removes the same right. An example is a fetch where the page is no-execute, the basic code forbids execution and the fetch mask also blocks the key. In that case the priority between the no-execute and basic-protection reasons has to coexist with the independent key-mask reason. The bench sets up such overlaps both directly and through thousands of random input combinations. It then compares the full fault vector against a reference model built from the rules above. Store denials blocked by both the basic code and the access mask are judged in the same way, checking that the protection, key and store bits all appear together.

// File: rtl/perm_chk_pkg.sv
package perm_chk_pkg;

  // right positions inside a 3-bit permission mask
  localparam int P_R = 0;
  localparam int P_W = 1;
  localparam int P_X = 2;

  localparam logic [2:0] PERM_NONE = 3'b000;
  localparam logic [2:0] PERM_RX   = 3'b101;
  localparam logic [2:0] PERM_RW   = 3'b011;
  localparam logic [2:0] PERM_ALL  = 3'b111;

  // fault-status bit positions
  localparam int F_PROT  = 0;
  localparam int F_NXG   = 1;
  localparam int F_KEY   = 2;
  localparam int F_STORE = 3;
  localparam int FAULT_W = 4;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    MODE_NOKEY  = 2'd0,
    MODE_DKEY   = 2'd1,
    MODE_IKEY_A = 2'd2,
    MODE_IKEY_B = 2'd3
  } mode_e;

endpackage

// File: rtl/perm_basic.sv
module perm_basic
  import perm_chk_pkg::*;
(
  input  logic       prob_state,
  input  logic       seg_kp,
  input  logic       seg_ks,
  input  logic [2:0] pp_code,
  output logic [2:0] basic_perm
);

  logic sel_key;

  always_comb begin
    sel_key = prob_state ? seg_kp : seg_ks;
  end

  always_comb begin
    basic_perm = PERM_NONE;
    if (!sel_key) begin
      unique case (pp_code)
        3'd0, 3'd1, 3'd2: basic_perm = PERM_ALL;
        3'd3, 3'd6:       basic_perm = PERM_RX;
        default:          basic_perm = PERM_NONE;
      endcase
    end else begin
      unique case (pp_code)
        3'd2:       basic_perm = PERM_ALL;
        3'd1, 3'd3: basic_perm = PERM_RX;
        default:    basic_perm = PERM_NONE;
      endcase
    end
  end

endmodule

// File: rtl/perm_keymask.sv
module perm_keymask
  import perm_chk_pkg::*;
#(
  parameter int KEY_W = 5
) (
  input  logic [KEY_W-1:0]          stor_key,
  input  logic [1:0]                mmu_mode,
  input  logic [2*(1<<KEY_W)-1:0]   amr,
  input  logic [2*(1<<KEY_W)-1:0]   iamr,
  output logic [2:0]                key_perm
);

  localparam int NUM_KEYS = 1 << KEY_W;

  logic [1:0] amr_slice  [NUM_KEYS];
  logic [1:0] iamr_slice [NUM_KEYS];

  // key 0 owns the most significant pair
  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_slice
    assign amr_slice[g]  = amr [2*(NUM_KEYS-1-g) +: 2];
    assign iamr_slice[g] = iamr[2*(NUM_KEYS-1-g) +: 2];
  end

  logic [1:0] a_bits;
  logic       i_bit;
  logic       use_data;
  logic       use_fetch;

  always_comb begin
    a_bits    = amr_slice[stor_key];
    i_bit     = iamr_slice[stor_key][0];
    use_data  = (mode_e'(mmu_mode) != MODE_NOKEY);
    use_fetch = (mode_e'(mmu_mode) == MODE_IKEY_A) ||
                (mode_e'(mmu_mode) == MODE_IKEY_B);
    key_perm  = PERM_ALL;
    if (use_data) begin
      if (a_bits[1]) key_perm[P_W] = 1'b0;
      if (a_bits[0]) key_perm[P_R] = 1'b0;
    end
    if (use_fetch && i_bit) key_perm[P_X] = 1'b0;
  end

endmodule

// File: rtl/perm_fault.sv
module perm_fault
  import perm_chk_pkg::*;
(
  input  logic [1:0]         acc_type,
  input  logic [2:0]         basic_perm,
  input  logic [2:0]         nxg_perm,
  input  logic [2:0]         key_perm,
  output logic [2:0]         comb_perm,
  output logic               comb_grant,
  output logic [FAULT_W-1:0] comb_fault
);

  logic [2:0] need;
  logic       is_fetch;
  logic       is_store;

  always_comb begin
    is_fetch = (acc_e'(acc_type) == ACC_FETCH);
    is_store = (acc_e'(acc_type) == ACC_STORE);
    if (is_fetch)      need = 3'b100;
    else if (is_store) need = 3'b010;
    else               need = 3'b001;
  end

  always_comb begin
    comb_perm  = basic_perm & nxg_perm & key_perm;
    comb_grant = ((need & ~comb_perm) == 3'b000);
    comb_fault = '0;
    if (!comb_grant) begin
      if (is_fetch) begin
        if (!nxg_perm[P_X])        comb_fault[F_NXG]  = 1'b1;
        else if (!basic_perm[P_X]) comb_fault[F_PROT] = 1'b1;
        if (!key_perm[P_X])        comb_fault[F_KEY]  = 1'b1;
      end else begin
        if ((need & ~basic_perm) != 3'b000) comb_fault[F_PROT] = 1'b1;
        if ((need & ~key_perm)   != 3'b000) comb_fault[F_KEY]  = 1'b1;
        if (is_store)                       comb_fault[F_STORE] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/perm_chk_top.sv
module perm_chk_top
  import perm_chk_pkg::*;
#(
  parameter int KEY_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      chk_en,
  input  logic [1:0]                acc_type,
  input  logic                      prob_state,
  input  logic                      seg_kp,
  input  logic                      seg_ks,
  input  logic [1:0]                pp_lo,
  input  logic                      pp_hi,
  input  logic                      no_exec,
  input  logic                      guarded,
  input  logic [KEY_W-1:0]          stor_key,
  input  logic [1:0]                mmu_mode,
  input  logic [2*(1<<KEY_W)-1:0]   amr,
  input  logic [2*(1<<KEY_W)-1:0]   iamr,
  output logic                      res_vld,
  output logic [2:0]                res_perm,
  output logic                      res_grant,
  output logic [3:0]                res_fault
);

  logic [2:0]         basic_perm;
  logic [2:0]         nxg_perm;
  logic [2:0]         key_perm;
  logic [2:0]         comb_perm;
  logic               comb_grant;
  logic [FAULT_W-1:0] comb_fault;

  perm_basic i_basic (
    .prob_state (prob_state),
    .seg_kp     (seg_kp),
    .seg_ks     (seg_ks),
    .pp_code    ({pp_hi, pp_lo}),
    .basic_perm (basic_perm)
  );

  always_comb begin
    nxg_perm = (no_exec || guarded) ? PERM_RW : PERM_ALL;
  end

  perm_keymask #(.KEY_W(KEY_W)) i_keymask (
    .stor_key (stor_key),
    .mmu_mode (mmu_mode),
    .amr      (amr),
    .iamr     (iamr),
    .key_perm (key_perm)
  );

  perm_fault i_fault (
    .acc_type   (acc_type),
    .basic_perm (basic_perm),
    .nxg_perm   (nxg_perm),
    .key_perm   (key_perm),
    .comb_perm  (comb_perm),
    .comb_grant (comb_grant),
    .comb_fault (comb_fault)
  );

  // output stage: next-state and register processes
  logic               vld_d;
  logic [2:0]         perm_d;
  logic               grant_d;
  logic [FAULT_W-1:0] fault_d;

  always_comb begin
    vld_d   = chk_en;
    perm_d  = res_perm;
    grant_d = res_grant;
    fault_d = res_fault;
    if (chk_en) begin
      perm_d  = comb_perm;
      grant_d = comb_grant;
      fault_d = comb_fault;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld   <= 1'b0;
      res_perm  <= '0;
      res_grant <= 1'b0;
      res_fault <= '0;
    end else begin
      res_vld   <= vld_d;
      res_perm  <= perm_d;
      res_grant <= grant_d;
      res_fault <= fault_d;
    end
  end

endmodule

// File: rtl/perm_chk_sva.sv
module perm_chk_sva
  import perm_chk_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       chk_en,
  input logic [1:0] acc_type,
  input logic [1:0] mmu_mode,
  input logic       res_vld,
  input logic [2:0] res_perm,
  input logic       res_grant,
  input logic [3:0] res_fault
);

  // R11
  grant_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_grant) |-> (res_fault == 4'b0000));

  // R9
  deny_has_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_grant) |-> (res_fault[2:0] != 3'b000));

  // R9
  nxg_over_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> !(res_fault[F_NXG] && res_fault[F_PROT]));

  // R10
  store_bit_only_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |=> (res_fault[F_STORE] == (($past(acc_type) == ACC_STORE) && !res_grant)));

  // R10
  nxg_only_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && acc_type != ACC_FETCH) |=> !res_fault[F_NXG]);

  // R7
  nokey_no_keyfault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && mmu_mode == MODE_NOKEY) |=> !res_fault[F_KEY]);

  // R12
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |=> ($stable(res_perm) && $stable(res_grant) && $stable(res_fault) && !res_vld));

endmodule

bind perm_chk_top perm_chk_sva i_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .chk_en    (chk_en),
  .acc_type  (acc_type),
  .mmu_mode  (mmu_mode),
  .res_vld   (res_vld),
  .res_perm  (res_perm),
  .res_grant (res_grant),
  .res_fault (res_fault)
);

// File: tb/test_perm_chk_top.sv
`timescale 1ns/1ps
module test_perm_chk_top;

  logic        clk;
  logic        rst_n;
  logic        chk_en;
  logic [1:0]  acc_type;
  logic        prob_state, seg_kp, seg_ks;
  logic [1:0]  pp_lo;
  logic        pp_hi, no_exec, guarded;
  logic [4:0]  stor_key;
  logic [1:0]  mmu_mode;
  logic [63:0] amr, iamr;
  logic        res_vld;
  logic [2:0]  res_perm;
  logic        res_grant;
  logic [3:0]  res_fault;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  perm_chk_top i_perm_chk_top (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .acc_type(acc_type),
    .prob_state(prob_state), .seg_kp(seg_kp), .seg_ks(seg_ks),
    .pp_lo(pp_lo), .pp_hi(pp_hi), .no_exec(no_exec), .guarded(guarded),
    .stor_key(stor_key), .mmu_mode(mmu_mode), .amr(amr), .iamr(iamr),
    .res_vld(res_vld), .res_perm(res_perm), .res_grant(res_grant),
    .res_fault(res_fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model written from the requirement text
  logic [2:0] e_perm;
  logic       e_grant;
  logic [3:0] e_fault;

  task automatic model();
    int key, code, pos;
    logic [2:0] b, n, k, need;
    key  = prob_state ? int'(seg_kp) : int'(seg_ks);
    code = int'({pp_hi, pp_lo});
    if (key == 0) b = (code <= 2) ? 3'b111 : ((code == 3 || code == 6) ? 3'b101 : 3'b000);
    else          b = (code == 2) ? 3'b111 : ((code == 1 || code == 3) ? 3'b101 : 3'b000);
    n = (no_exec | guarded) ? 3'b011 : 3'b111;
    k = 3'b111;
    pos = 2 * (31 - int'(stor_key));
    if (mmu_mode != 0) begin
      if (amr[pos+1]) k[1] = 1'b0;
      if (amr[pos])   k[0] = 1'b0;
    end
    if (mmu_mode >= 2 && iamr[pos]) k[2] = 1'b0;
    need = (acc_type == 0) ? 3'b100 : ((acc_type == 2) ? 3'b010 : 3'b001);
    e_perm  = b & n & k;
    e_grant = ((e_perm & need) != 0);
    e_fault = 4'b0;
    if (!e_grant) begin
      if (acc_type == 0) begin
        if (!n[2]) e_fault[1] = 1'b1;
        else if (!b[2]) e_fault[0] = 1'b1;
        if (!k[2]) e_fault[2] = 1'b1;
      end else begin
        if ((b & need) == 0) e_fault[0] = 1'b1;
        if ((k & need) == 0) e_fault[2] = 1'b1;
        if (acc_type == 2)   e_fault[3] = 1'b1;
      end
    end
  endtask

  task automatic clear_in();
    acc_type = 0; prob_state = 0; seg_kp = 0; seg_ks = 0;
    pp_lo = 0; pp_hi = 0; no_exec = 0; guarded = 0;
    stor_key = 0; mmu_mode = 0; amr = '0; iamr = '0;
  endtask

  // inputs already set; load them, compare after the capturing edge
  task automatic apply(input string tag);
    string ftag;
    model();
    chk_en = 1'b1;
    @(negedge clk);
    chk_en = 1'b0;
    ftag = e_grant ? "R11" : ((acc_type == 0) ? "R9" : "R10");
    check({"R12 vld ", tag}, int'(res_vld), 1);
    check({tag, " perm"}, int'(res_perm), int'(e_perm));
    check({"R8 grant ", tag}, int'(res_grant), int'(e_grant));
    check({ftag, " fault ", tag}, int'(res_fault), int'(e_fault));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; chk_en = 1'b0;
    clear_in();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 vld",   int'(res_vld),   0);
    check("R1 perm",  int'(res_perm),  0);
    check("R1 grant", int'(res_grant), 0);
    check("R1 fault", int'(res_fault), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'({res_vld, res_perm, res_grant, res_fault}), 0);

    // R2: full pp table for both keys, load and store and fetch
    for (int kk = 0; kk < 2; kk++)
      for (int c = 0; c < 8; c++)
        for (int a = 0; a < 3; a++) begin
          clear_in(); seg_ks = kk[0]; {pp_hi, pp_lo} = c[2:0]; acc_type = a[1:0];
          apply("R2");
        end

    // R3: key picked by privilege state
    clear_in(); prob_state = 1; seg_kp = 1; seg_ks = 0; {pp_hi, pp_lo} = 3'd0; acc_type = 1;
    apply("R3 user key1 code0");
    clear_in(); prob_state = 0; seg_kp = 1; seg_ks = 0; {pp_hi, pp_lo} = 3'd0; acc_type = 1;
    apply("R3 super key0 code0");
    clear_in(); prob_state = 1; seg_kp = 0; seg_ks = 1; {pp_hi, pp_lo} = 3'd6; acc_type = 0;
    apply("R3 user key0 code6");

    // R4: noexec / guarded remove only execute
    clear_in(); no_exec = 1; acc_type = 2; apply("R4 noexec store");
    clear_in(); guarded = 1; acc_type = 1; apply("R4 guarded load");
    clear_in(); guarded = 1; acc_type = 0; apply("R4 guarded fetch");

    // R5: access mask slice at both extremes of the key range
    clear_in(); mmu_mode = 1; stor_key = 0;  amr[63] = 1; acc_type = 2; apply("R5 key0 store");
    clear_in(); mmu_mode = 1; stor_key = 0;  amr[62] = 1; acc_type = 1; apply("R5 key0 load");
    clear_in(); mmu_mode = 1; stor_key = 0;  amr[62] = 1; acc_type = 2; apply("R5 key0 load bit store");
    clear_in(); mmu_mode = 3; stor_key = 31; amr[1] = 1;  acc_type = 2; apply("R5 key31 store");
    clear_in(); mmu_mode = 2; stor_key = 31; amr[0] = 1;  acc_type = 1; apply("R5 key31 load");
    clear_in(); mmu_mode = 1; stor_key = 7;  amr = ~(64'h3 << 48); acc_type = 2; apply("R5 other keys");

    // R6: fetch mask only in modes 2/3, only execute
    clear_in(); mmu_mode = 2; stor_key = 4; iamr[54] = 1; acc_type = 0; apply("R6 mode2 fetch");
    clear_in(); mmu_mode = 3; stor_key = 4; iamr[54] = 1; acc_type = 1; apply("R6 mode3 load");
    clear_in(); mmu_mode = 1; stor_key = 4; iamr = '1;    acc_type = 0; apply("R6 mode1 ignored");
    clear_in(); mmu_mode = 3; stor_key = 4; iamr[55] = 1; acc_type = 0; apply("R6 high bit ignored");

    // R7: mode 0 ignores both masks
    clear_in(); mmu_mode = 0; amr = '1; iamr = '1; acc_type = 2; apply("R7 store");
    clear_in(); mmu_mode = 0; amr = '1; iamr = '1; acc_type = 0; apply("R7 fetch");

    // R9 overlap: noexec + basic deny + fetch mask in one fetch
    clear_in(); no_exec = 1; seg_ks = 1; {pp_hi, pp_lo} = 3'd0; mmu_mode = 2; iamr = '1; acc_type = 0;
    apply("R9 triple overlap");
    clear_in(); seg_ks = 1; {pp_hi, pp_lo} = 3'd0; mmu_mode = 3; iamr = '1; acc_type = 0;
    apply("R9 prot plus key");
    // R10 overlap: store blocked by both basic and mask
    clear_in(); {pp_hi, pp_lo} = 3'd3; mmu_mode = 1; amr = '1; acc_type = 2;
    apply("R10 store overlap");
    // R8: code 3 treated as load
    clear_in(); acc_type = 3; mmu_mode = 1; amr = '1; apply("R8 rsvd acc");

    // R12: hold while disabled
    clear_in(); acc_type = 1; apply("R12 base");
    begin
      logic [2:0] hp; logic hg; logic [3:0] hf;
      hp = res_perm; hg = res_grant; hf = res_fault;
      {pp_hi, pp_lo} = 3'd7; acc_type = 2;
      @(negedge clk);
      check("R12 hold vld",   int'(res_vld),   0);
      check("R12 hold perm",  int'(res_perm),  int'(hp));
      check("R12 hold grant", int'(res_grant), int'(hg));
      check("R12 hold fault", int'(res_fault), int'(hf));
    end

    // random sweep, all requirements together
    for (int i = 0; i < 4000; i++) begin
      acc_type = 2'($urandom); prob_state = 1'($urandom);
      seg_kp = 1'($urandom); seg_ks = 1'($urandom);
      {pp_hi, pp_lo} = 3'($urandom);
      no_exec = ($urandom % 4) == 0; guarded = ($urandom % 4) == 0;
      stor_key = 5'($urandom); mmu_mode = 2'($urandom);
      amr  = {$urandom, $urandom} & {$urandom, $urandom};
      iamr = {$urandom, $urandom} & {$urandom, $urandom};
      apply("R8 random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule